// File: doc/BRIEF.md
# Range-Checked Jump Table Dispatcher

This block resolves a dense multi-way branch. It receives the address of the word that follows a branch call (the table base) and a selector value. It then reads an inline table through a single-port read interface. The first table word holds the value of the highest case and the second holds the number of cases. The target entries follow, and they are stored from the highest case down to the lowest. Each entry is an offset relative to its own address, so the jump address is the entry address plus the entry contents.

The block forms the distance from the highest case down to the selector, modulo the word width. It treats that distance as unsigned and compares it once against the case count, which decides whether the selector is in range. When the selector is in range, the block fetches the matching entry and reports the resolved jump address. When it is out of range, the block reports the first address past the table and makes no third read. The block only computes the next program counter. It writes nothing, and the selector it was given is only held internally.

Back-pressure rules are as follows:
- A job request (`start_valid`) must stay asserted until `start_ready` is seen high. `start_ready` is high only while the block is idle.
- A read request keeps its address stable until `rd_req_ready` accepts it.
- The read response port has no back-pressure. The block always takes `rd_rsp_valid` when it is waiting for data.
- The `done` pulse also has no back-pressure, so the user must capture it in that cycle.

Top module: `case_dispatch`

## Requirements
- R1: A job is taken when `start_valid` and `start_ready` are both high at a clock edge. `start_ready` is high only while idle, and `start_valid` has no effect on the running job while the block is busy.
- R2: Each job first reads address P and then address P+1. At most one read is outstanding. A request holds `rd_addr` stable until `rd_req_ready`, and the next request is issued only after the response to the previous one has arrived.
- R3: The index is d = (last − selector) mod 2^DATA_W. The selector is in range exactly when d < n, compared unsigned.
- R4: In range, the third read goes to P+2+d, `next_pc` = P+2+d+entry, and `in_range` = 1.
- R5: Out of range, exactly two reads are made, `next_pc` = P+2+n, and `in_range` = 0.
- R6: With n = 0, every selector is out of range and `next_pc` = P+2.
- R7: `done` is high for exactly one cycle, and `next_pc` and `in_range` are valid in that cycle. `start_ready` is high again in the following cycle.
- R8: All address sums wrap modulo 2^ADDR_W. This includes negative offsets (an entry read as two's complement) and tables that cross the top of the address space.
- R9: `rd_rsp_valid` is ignored while no read request has been accepted, including while a request is waiting for `rd_req_ready`.
- R10: After reset, `start_ready` = 1, `done` = 0 and `rd_req_valid` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Job request |
| start_ready | output | 1 | High when a job can be taken (idle) |
| start_base | input | ADDR_W | Table base P (word after the call) |
| start_sel | input | DATA_W | Selector value |
| rd_req_valid | output | 1 | Read request valid |
| rd_req_ready | input | 1 | Read request accepted |
| rd_addr | output | ADDR_W | Read word address |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | DATA_W | Read data word |
| done | output | 1 | One-cycle completion pulse |
| next_pc | output | ADDR_W | Resolved next program counter |
| in_range | output | 1 | 1 = jumped through the table, 0 = fell through |

## Verification
The bench builds the block with its defaults, ADDR_W = DATA_W = 16. At these widths the wrap of the index and the wrap of the addresses both become observable:
- A selector above the highest case produces an index of 0xFFFF.
- A table based at 0xFFFE places its entries at addresses 0 and 1.
- The entry 0xFFF0 acts as a backward jump.

The memory model in the bench can hold off `rd_req_ready` and delay responses by a programmable amount. While a request is stalled, it can also send stray response pulses, which is how the port rules are exercised.

// File: rtl/csd_pkg.sv
package csd_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_RQ_LAST,
    S_WT_LAST,
    S_RQ_CNT,
    S_WT_CNT,
    S_RQ_ENT,
    S_WT_ENT,
    S_DONE
  } csd_state_e;
endpackage

// File: rtl/csd_range.sv
module csd_range #(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] last_case,
  input  logic [DATA_W-1:0] sel,
  input  logic [DATA_W-1:0] count,
  output logic [DATA_W-1:0] idx,
  output logic              hit
);
  // distance down from the highest case; wraps for selectors above it
  always_comb begin
    idx = last_case - sel;
    hit = (idx < count);
  end
endmodule

// File: rtl/csd_addr.sv
module csd_addr #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [DATA_W-1:0] idx,
  input  logic [DATA_W-1:0] word,
  output logic [ADDR_W-1:0] a_cnt,
  output logic [ADDR_W-1:0] a_entry,
  output logic [ADDR_W-1:0] a_fall,
  output logic [ADDR_W-1:0] a_jump
);
  localparam logic [ADDR_W-1:0] HDR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  always_comb begin
    a_cnt   = base + ONE;
    a_entry = base + HDR + ADDR_W'(idx);
    a_fall  = base + HDR + ADDR_W'(word);
    a_jump  = a_entry + ADDR_W'(word);
  end
endmodule

// File: rtl/csd_ctrl.sv
module csd_ctrl
  import csd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start_valid,
  input  logic       rd_req_ready,
  input  logic       rd_rsp_valid,
  input  logic       hit,
  output csd_state_e state,
  output logic       start_fire,
  output logic       rd_req_valid,
  output logic       cap_last,
  output logic       cap_cnt,
  output logic       cap_ent,
  output logic       done
);
  csd_state_e nxt;

  always_comb begin
    start_fire   = (state == S_IDLE) && start_valid;
    rd_req_valid = (state == S_RQ_LAST) || (state == S_RQ_CNT) || (state == S_RQ_ENT);
    cap_last     = (state == S_WT_LAST) && rd_rsp_valid;
    cap_cnt      = (state == S_WT_CNT)  && rd_rsp_valid;
    cap_ent      = (state == S_WT_ENT)  && rd_rsp_valid;
    done         = (state == S_DONE);
    nxt          = state;
    unique case (state)
      S_IDLE:    if (start_valid)  nxt = S_RQ_LAST;
      S_RQ_LAST: if (rd_req_ready) nxt = S_WT_LAST;
      S_WT_LAST: if (rd_rsp_valid) nxt = S_RQ_CNT;
      S_RQ_CNT:  if (rd_req_ready) nxt = S_WT_CNT;
      S_WT_CNT:  if (rd_rsp_valid) nxt = hit ? S_RQ_ENT : S_DONE;
      S_RQ_ENT:  if (rd_req_ready) nxt = S_WT_ENT;
      S_WT_ENT:  if (rd_rsp_valid) nxt = S_DONE;
      S_DONE:    nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= S_IDLE;
    else        state <= nxt;
  end

  // R1: idle never overlaps a read request or a completion
  p_idle_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (!rd_req_valid && !done));
  // R2: an accepted request is followed by a cycle without a request
  p_single_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && rd_req_ready) |=> !rd_req_valid);
  // R7: completion lasts one cycle and returns to idle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && state == S_IDLE));
  // R9: completion only follows a response
  p_done_after_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rd_rsp_valid));
endmodule

// File: rtl/case_dispatch.sv
module case_dispatch
  import csd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic [ADDR_W-1:0] start_base,
  input  logic [DATA_W-1:0] start_sel,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rsp_valid,
  input  logic [DATA_W-1:0] rd_rsp_data,
  output logic              done,
  output logic [ADDR_W-1:0] next_pc,
  output logic              in_range
);
  csd_state_e        state;
  logic              start_fire, cap_last, cap_cnt, cap_ent, hit;
  logic [ADDR_W-1:0] base_q, a_cnt, a_entry, a_fall, a_jump, pc_q;
  logic [DATA_W-1:0] sel_q, last_q, idx_q, idx_now;
  logic              inr_q;

  csd_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_valid  (start_valid),
    .rd_req_ready (rd_req_ready),
    .rd_rsp_valid (rd_rsp_valid),
    .hit          (hit),
    .state        (state),
    .start_fire   (start_fire),
    .rd_req_valid (rd_req_valid),
    .cap_last     (cap_last),
    .cap_cnt      (cap_cnt),
    .cap_ent      (cap_ent),
    .done         (done)
  );

  csd_range #(.DATA_W(DATA_W)) u_range (
    .last_case (last_q),
    .sel       (sel_q),
    .count     (rd_rsp_data),
    .idx       (idx_now),
    .hit       (hit)
  );

  csd_addr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_addr (
    .base    (base_q),
    .idx     (idx_q),
    .word    (rd_rsp_data),
    .a_cnt   (a_cnt),
    .a_entry (a_entry),
    .a_fall  (a_fall),
    .a_jump  (a_jump)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      base_q <= '0;
      sel_q  <= '0;
      last_q <= '0;
      idx_q  <= '0;
      pc_q   <= '0;
      inr_q  <= 1'b0;
    end else begin
      if (start_fire) begin
        base_q <= start_base;
        sel_q  <= start_sel;
      end
      if (cap_last) last_q <= rd_rsp_data;
      if (cap_cnt) begin
        idx_q <= idx_now;
        if (!hit) begin
          pc_q  <= a_fall;
          inr_q <= 1'b0;
        end
      end
      if (cap_ent) begin
        pc_q  <= a_jump;
        inr_q <= 1'b1;
      end
    end
  end

  always_comb begin
    start_ready = (state == S_IDLE);
    next_pc     = pc_q;
    in_range    = inr_q;
    unique case (state)
      S_RQ_CNT: rd_addr = a_cnt;
      S_RQ_ENT: rd_addr = a_entry;
      default:  rd_addr = base_q;
    endcase
  end

  // R2: a stalled request keeps its address
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_addr)));
  // R1: job parameters are frozen while busy
  p_busy_frozen_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !start_ready |=> ($stable(base_q) && $stable(sel_q)));
  // R7: result stays put in the cycle after completion
  p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(next_pc) && $stable(in_range)));
endmodule

// File: tb/case_dispatch_test.sv
module case_dispatch_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0;
  logic        start_ready;
  logic [15:0] start_base = '0;
  logic [15:0] start_sel = '0;
  logic        rd_req_valid;
  logic        rd_req_ready = 1'b0;
  logic [15:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [15:0] rd_rsp_data = '0;
  logic        done;
  logic [15:0] next_pc;
  logic        in_range;

  always #5 clk = ~clk;

  case_dispatch #(.ADDR_W(16), .DATA_W(16)) uut (
    .clk(clk), .rst_n(rst_n),
    .start_valid(start_valid), .start_ready(start_ready),
    .start_base(start_base), .start_sel(start_sel),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .done(done), .next_pc(next_pc), .in_range(in_range)
  );

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  logic [15:0] mem [0:255];
  logic [15:0] log_addr [0:7];
  int nreads = 0;
  int stall = 0;
  int lat = 0;
  bit inject = 0;
  bit poke = 0;
  bit pend = 0;
  int lat_ctr = 0;
  int stall_ctr = 0;
  logic [15:0] paddr = '0;

  // memory model: decides ready and response between edges
  always @(negedge clk) begin
    rd_rsp_valid = 1'b0;
    rd_req_ready = 1'b0;
    if (pend) begin
      if (lat_ctr == 0) begin
        rd_rsp_valid = 1'b1;
        rd_rsp_data  = mem[paddr[7:0]];
        pend = 0;
      end else lat_ctr--;
    end else if (rd_req_valid) begin
      if (stall_ctr >= stall) begin
        rd_req_ready = 1'b1;
        stall_ctr = 0;
        pend = 1;
        paddr = rd_addr;
        lat_ctr = lat;
        if (nreads < 8) log_addr[nreads] = rd_addr;
        nreads++;
      end else begin
        stall_ctr++;
        if (inject) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = 16'h7777;
        end
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d cycles expected<=100000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  logic [15:0] r_pc;
  logic        r_ir;
  logic        r_done_after, r_rdy_after;
  int          busy_ready_seen;

  task automatic run(input logic [15:0] b, input logic [15:0] s);
    int c = 0;
    nreads = 0;
    busy_ready_seen = 0;
    @(negedge clk);
    start_valid = 1'b1; start_base = b; start_sel = s;
    @(negedge clk);
    start_valid = poke; start_base = 16'h0099; start_sel = 16'h5555;
    while (!done && c < 500) begin
      if (start_ready) busy_ready_seen++;
      @(negedge clk);
      c++;
    end
    start_valid = 1'b0;
    r_pc = next_pc;
    r_ir = in_range;
    @(negedge clk);
    r_done_after = done;
    r_rdy_after = start_ready;
  endtask

  task automatic expect_hit(input string tag, input logic [15:0] b, input logic [15:0] s,
                            input logic [15:0] ent, input logic [15:0] pc);
    run(b, s);
    chk(r_ir == 1'b1, {tag, " R4 in_range"}, 16'(r_ir), 16'd1);
    chk(r_pc == pc, {tag, " R4 next_pc"}, r_pc, pc);
    chk(nreads == 3, {tag, " R4 read count"}, 16'(nreads), 16'd3);
    chk(log_addr[0] == b && log_addr[1] == b + 16'd1, {tag, " R2 header reads"}, log_addr[1], b + 16'd1);
    chk(log_addr[2] == ent, {tag, " R3 entry address"}, log_addr[2], ent);
    chk(!r_done_after && r_rdy_after, {tag, " R7 pulse"}, 16'(r_done_after), 16'd0);
  endtask

  task automatic expect_miss(input string tag, input logic [15:0] b, input logic [15:0] s,
                             input logic [15:0] pc);
    run(b, s);
    chk(r_ir == 1'b0, {tag, " R5 in_range"}, 16'(r_ir), 16'd0);
    chk(r_pc == pc, {tag, " R5 next_pc"}, r_pc, pc);
    chk(nreads == 2, {tag, " R5 read count"}, 16'(nreads), 16'd2);
    chk(!r_done_after && r_rdy_after, {tag, " R7 pulse"}, 16'(r_done_after), 16'd0);
  endtask

  task automatic t_reset();
    chk(start_ready == 1'b1, "R10 start_ready", 16'(start_ready), 16'd1);
    chk(done == 1'b0, "R10 done", 16'(done), 16'd0);
    chk(rd_req_valid == 1'b0, "R10 rd_req_valid", 16'(rd_req_valid), 16'd0);
  endtask

  // table at 0x0040: last=10, n=5, entries at 0x42..0x46
  task automatic load_main();
    mem[8'h40] = 16'd10;
    mem[8'h41] = 16'd5;
    mem[8'h42] = 16'h0010;
    mem[8'h43] = 16'hFFF0;
    mem[8'h44] = 16'h0100;
    mem[8'h45] = 16'h0200;
    mem[8'h46] = 16'h0020;
  endtask

  task automatic t_middle();
    expect_hit("mid", 16'h0040, 16'd8, 16'h0044, 16'h0144);
  endtask

  task automatic t_edges();
    expect_hit("top case R3", 16'h0040, 16'd10, 16'h0042, 16'h0052);
    expect_hit("bottom case R3", 16'h0040, 16'd6, 16'h0046, 16'h0066);
    expect_miss("below range R3", 16'h0040, 16'd5, 16'h0047);
    expect_miss("above range R3", 16'h0040, 16'd11, 16'h0047);
  endtask

  task automatic t_zero();
    mem[8'h80] = 16'd3;
    mem[8'h81] = 16'd0;
    expect_miss("empty R6", 16'h0080, 16'd3, 16'h0082);
    expect_miss("empty2 R6", 16'h0080, 16'd0, 16'h0082);
  endtask

  task automatic t_negoff();
    expect_hit("backward R8", 16'h0040, 16'd9, 16'h0043, 16'h0033);
  endtask

  task automatic t_wrap();
    mem[8'hFE] = 16'd100;
    mem[8'hFF] = 16'd2;
    mem[8'h00] = 16'h0009;
    mem[8'h01] = 16'h0005;
    expect_hit("wrap R8", 16'hFFFE, 16'd99, 16'h0001, 16'h0006);
    expect_miss("wrap fall R8", 16'hFFFE, 16'd98, 16'h0002);
  endtask

  task automatic t_stall();
    stall = 2; lat = 3; inject = 1;
    expect_hit("stall R9", 16'h0040, 16'd8, 16'h0044, 16'h0144);
    expect_miss("stall miss R9", 16'h0040, 16'd2, 16'h0047);
    stall = 0; lat = 0; inject = 0;
  endtask

  task automatic t_busy();
    poke = 1;
    stall = 1; lat = 1;
    expect_hit("busy R1", 16'h0040, 16'd7, 16'h0045, 16'h0245);
    chk(busy_ready_seen == 0, "R1 ready while busy", 16'(busy_ready_seen), 16'd0);
    poke = 0; stall = 0; lat = 0;
    @(negedge clk);
    chk(start_ready && !rd_req_valid, "R1 no extra job", 16'(rd_req_valid), 16'd0);
  endtask

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 8; i++) log_addr[i] = 16'h0000;
    load_main();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_middle();
    t_edges();
    t_zero();
    t_negoff();
    t_wrap();
    t_stall();
    t_busy();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule